// File: doc/BRIEF.md
# Character Display Write Sequencer

This block turns single-byte write requests into correctly timed write cycles on the parallel interface of a character display of the common two-register kind. Each request says whether its byte is an instruction (a command for the display controller) or a character (an ASCII code to be shown). The sequencer drives the byte onto an 8-bit data bus, selects the instruction or data register with a register-select line, keeps the read/write line at write, and then fires one enable pulse of programmable width. It never reads the display. Instead, a fixed wait follows each command, and the clear command gets a longer wait.

After reset the sequencer can start the display by itself. It writes four instructions in a fixed order: an 8-bit bus, two lines and a 5x8 font (0x38); display on with the cursor shown (0x0E); entry mode with an incrementing address so that text runs left to right (0x06); and clear (0x01). Only after this does it accept user requests. User requests arrive on a valid/ready handshake, and the sequencer holds ready low from acceptance until the wait of that command has run out.

Top module: `lcd_write_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, lcd_en, lcd_rs and lcd_rw are 0 and req_ready is 0.
- R2: With AUTO_INIT set, four instruction writes (lcd_rs = 0) carrying 0x38, 0x0E, 0x06 and 0x01, in that order, complete before req_ready first rises.
- R3: lcd_rw is 0 in every cycle (write only).
- R4: An accepted request with req_is_data = 0 produces one enable pulse with lcd_rs = 0, and one with req_is_data = 1 produces a pulse with lcd_rs = 1. In both cases lcd_data equals req_byte during the pulse.
- R5: lcd_data and lcd_rs are stable for SETUP_CYC cycles before lcd_en rises. lcd_en rises SETUP_CYC+1 cycles after the cycle in which the handshake completes.
- R6: lcd_en stays high for exactly EN_CYC cycles, and lcd_data does not change while it is high.
- R7: lcd_rs is 0 from the cycle in which lcd_en falls.
- R8: req_ready rises WAIT_CYC cycles after lcd_en falls. For an instruction whose byte is 0x01 (clear) the delay is CLEAR_WAIT_CYC instead. A character byte 0x01 gets the short wait.
- R9: req_ready is 0 from acceptance until the wait has expired. A request presented while req_ready is 0 is ignored and causes no enable pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_is_data | input | 1 | 1: character byte, 0: instruction byte |
| req_byte | input | 8 | Byte to write |
| lcd_data | output | 8 | Display data bus |
| lcd_rs | output | 1 | Register select, 1 = data register |
| lcd_rw | output | 1 | Read/write, held at 0 (write) |
| lcd_en | output | 1 | Enable strobe, active high |

## Verification
The embedded assertions check these properties on every cycle:
- data and register select do not move in the cycle before enable rises;
- data stays stable while enable is high;
- enable is high for exactly EN_CYC cycles, counted by a run counter;
- register select is low when enable falls;
- ready and enable are never high together.

The following are shown only by the bench's scenarios:
- the byte order of the power-up sequence;
- the choice between the short and the long wait depending on the register and the byte;
- the exact delay from handshake to strobe;
- the rule that requests made while busy leave no trace.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_WAIT   = 2'd3
  } seq_state_t;

  localparam int BOOT_LEN = 4;
  localparam int BOOT_IDX_W = 3;

  localparam logic [7:0] CMD_FUNC_8B_2L = 8'h38;
  localparam logic [7:0] CMD_DISP_ON    = 8'h0E;
  localparam logic [7:0] CMD_ENTRY_INC  = 8'h06;
  localparam logic [7:0] CMD_CLEAR      = 8'h01;

endpackage

// File: rtl/lcdseq_boot_rom.sv
module lcdseq_boot_rom
  import lcdseq_pkg::*;
#(
  parameter int IDX_W = BOOT_IDX_W
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       cmd
);

  always_comb begin
    case (idx)
      IDX_W'(0): cmd = CMD_FUNC_8B_2L;
      IDX_W'(1): cmd = CMD_DISP_ON;
      IDX_W'(2): cmd = CMD_ENTRY_INC;
      default:   cmd = CMD_CLEAR;
    endcase
  end

endmodule

// File: rtl/lcdseq_timer.sv
module lcdseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/lcdseq_pins.sv
module lcdseq_pins
  import lcdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t state_n,
  input  logic [7:0] byte_n,
  input  logic       rs_n,
  output logic [7:0] lcd_data,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lcd_data <= '0;
      lcd_rs   <= 1'b0;
      lcd_rw   <= 1'b0;
      lcd_en   <= 1'b0;
    end else begin
      lcd_data <= byte_n;
      lcd_rs   <= rs_n && ((state_n == ST_SETUP) || (state_n == ST_STROBE));
      lcd_rw   <= 1'b0;
      lcd_en   <= (state_n == ST_STROBE);
    end
  end

  // R6: data is frozen for the whole strobe
  assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (lcd_en && $past(lcd_en)) |-> $stable(lcd_data));

endmodule

// File: rtl/lcd_write_seq.sv
module lcd_write_seq
  import lcdseq_pkg::*;
#(
  parameter int SETUP_CYC      = 2,
  parameter int EN_CYC         = 8,
  parameter int WAIT_CYC       = 40,
  parameter int CLEAR_WAIT_CYC = 1600,
  parameter bit AUTO_INIT      = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_is_data,
  input  logic [7:0] req_byte,
  output logic [7:0] lcd_data,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en
);

  localparam int MAX_AB  = (SETUP_CYC > EN_CYC) ? SETUP_CYC : EN_CYC;
  localparam int MAX_CD  = (WAIT_CYC > CLEAR_WAIT_CYC) ? WAIT_CYC : CLEAR_WAIT_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int RUN_W   = $clog2(EN_CYC + 2);
  localparam logic [BOOT_IDX_W-1:0] BOOT_END   = BOOT_IDX_W'(BOOT_LEN);
  localparam logic [BOOT_IDX_W-1:0] BOOT_START = AUTO_INIT ? '0 : BOOT_END;

  seq_state_t state_q, state_n;
  logic [7:0] cmd_byte_q, cmd_byte_n;
  logic       cmd_rs_q, cmd_rs_n;
  logic [BOOT_IDX_W-1:0] boot_idx_q, boot_idx_n;
  logic [7:0] boot_cmd;
  logic       boot_pending;
  logic       is_clear;
  logic       tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic       ready_q;

  lcdseq_boot_rom #(.IDX_W(BOOT_IDX_W)) boot_rom_i (
    .idx (boot_idx_q),
    .cmd (boot_cmd)
  );

  lcdseq_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign boot_pending = (boot_idx_q < BOOT_END);
  assign is_clear     = !cmd_rs_q && (cmd_byte_q == CMD_CLEAR);

  always_comb begin
    state_n    = state_q;
    cmd_byte_n = cmd_byte_q;
    cmd_rs_n   = cmd_rs_q;
    boot_idx_n = boot_idx_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    case (state_q)
      ST_IDLE: begin
        if (boot_pending) begin
          cmd_byte_n = boot_cmd;
          cmd_rs_n   = 1'b0;
          boot_idx_n = boot_idx_q + 1'b1;
          state_n    = ST_SETUP;
          tmr_load   = 1'b1;
          tmr_val    = CNT_W'(SETUP_CYC - 1);
        end else if (req_valid && ready_q) begin
          cmd_byte_n = req_byte;
          cmd_rs_n   = req_is_data;
          state_n    = ST_SETUP;
          tmr_load   = 1'b1;
          tmr_val    = CNT_W'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          state_n  = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(EN_CYC - 1);
        end
      end
      ST_STROBE: begin
        if (tmr_zero) begin
          state_n  = ST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = is_clear ? CNT_W'(CLEAR_WAIT_CYC - 1) : CNT_W'(WAIT_CYC - 1);
        end
      end
      default: begin
        if (tmr_zero) state_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cmd_byte_q <= '0;
      cmd_rs_q   <= 1'b0;
      boot_idx_q <= BOOT_START;
      ready_q    <= 1'b0;
    end else begin
      state_q    <= state_n;
      cmd_byte_q <= cmd_byte_n;
      cmd_rs_q   <= cmd_rs_n;
      boot_idx_q <= boot_idx_n;
      ready_q    <= (state_n == ST_IDLE) && (boot_idx_n >= BOOT_END);
    end
  end

  assign req_ready = ready_q;

  lcdseq_pins pins_i (
    .clk      (clk),
    .rst      (rst),
    .state_n  (state_n),
    .byte_n   (cmd_byte_n),
    .rs_n     (cmd_rs_n),
    .lcd_data (lcd_data),
    .lcd_rs   (lcd_rs),
    .lcd_rw   (lcd_rw),
    .lcd_en   (lcd_en)
  );

  // Strobe length monitor for the width property
  logic [RUN_W-1:0] en_run_q;
  always_ff @(posedge clk) begin
    if (rst)         en_run_q <= '0;
    else if (lcd_en) en_run_q <= en_run_q + 1'b1;
    else             en_run_q <= '0;
  end

  assert_en_width_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_en) |-> (en_run_q == RUN_W'(EN_CYC)));

  // R5: bus settled before the strobe begins
  assert_setup_settled_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_en) |-> ($stable(lcd_data) && $stable(lcd_rs)));

  assert_rs_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_en) |-> !lcd_rs);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    lcd_en |-> !req_ready);

  assert_ready_bus_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!lcd_en && !lcd_rs));

endmodule

// File: tb/lcd_write_seq_tb_top.sv
module lcd_write_seq_tb_top;

  localparam int SETUP = 3;
  localparam int ENW   = 8;
  localparam int WAITC = 12;
  localparam int CLRW  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_is_data = 1'b0;
  logic [7:0] req_byte = '0;
  logic req_ready, lcd_rs, lcd_rw, lcd_en;
  logic [7:0] lcd_data;

  always #5 clk = ~clk;

  lcd_write_seq #(
    .SETUP_CYC(SETUP), .EN_CYC(ENW), .WAIT_CYC(WAITC),
    .CLEAR_WAIT_CYC(CLRW), .AUTO_INIT(1'b1)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_data(req_is_data), .req_byte(req_byte), .lcd_data(lcd_data),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_wait(input bit rs, input logic [7:0] b);
    return (!rs && b == 8'h01) ? CLRW : WAITC;
  endfunction

  // expected strobe queue
  logic [7:0] q_byte [0:255];
  bit         q_rs   [0:255];
  bit         q_boot [0:255];
  int wr = 0, rd = 0;

  int cyc = 0, acc_neg = 0, fall_neg = 0, en_cnt = 0, cur_wait = 0;
  bit prev_en = 0, prev_ready = 0, wait_pend = 0;
  logic [7:0] cap_byte = '0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      chk(lcd_rw == 1'b0, "R3", "rw", lcd_rw, 0);
      if (lcd_en) chk(!req_ready, "R9", "ready during strobe", req_ready, 0);
      if (req_valid && req_ready) begin
        q_byte[wr[7:0]] = req_byte; q_rs[wr[7:0]] = req_is_data;
        q_boot[wr[7:0]] = 1'b0; wr++; acc_neg = cyc;
      end
      if (lcd_en && !prev_en) begin
        if (rd >= wr) begin
          chk(1'b0, "R9", "unexpected strobe", lcd_data, 0);
        end else begin
          chk(lcd_data == q_byte[rd[7:0]], q_boot[rd[7:0]] ? "R2" : "R4",
              "strobe byte", lcd_data, q_byte[rd[7:0]]);
          chk(lcd_rs == q_rs[rd[7:0]], q_boot[rd[7:0]] ? "R2" : "R4",
              "strobe rs", lcd_rs, q_rs[rd[7:0]]);
          if (!q_boot[rd[7:0]])
            chk(cyc - acc_neg == SETUP + 1, "R5", "accept to enable",
                cyc - acc_neg, SETUP + 1);
          cur_wait = exp_wait(lcd_rs, lcd_data);
          rd++;
        end
        cap_byte = lcd_data;
        en_cnt = 0;
      end
      if (lcd_en) begin
        en_cnt++;
        chk(lcd_data == cap_byte, "R6", "data hold", lcd_data, cap_byte);
      end
      if (!lcd_en && prev_en) begin
        chk(en_cnt == ENW, "R6", "enable width", en_cnt, ENW);
        chk(lcd_rs == 1'b0, "R7", "rs after strobe", lcd_rs, 0);
        fall_neg = cyc; wait_pend = 1'b1;
      end
      if (req_ready && !prev_ready && wait_pend) begin
        chk(cyc - fall_neg == cur_wait, "R8", "wait length", cyc - fall_neg, cur_wait);
        wait_pend = 1'b0;
      end
      prev_en = lcd_en; prev_ready = req_ready;
    end
  end

  task automatic send(input bit d, input logic [7:0] b, input bit poke);
    @(posedge clk); #1;
    req_valid = 1'b1; req_is_data = d; req_byte = b;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (poke) begin
      req_valid = 1'b1; req_is_data = 1'b1; req_byte = 8'hAA;
      @(posedge clk); #1;
      req_valid = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    logic [7:0] boot_seq [0:3];
    boot_seq[0] = 8'h38; boot_seq[1] = 8'h0E;
    boot_seq[2] = 8'h06; boot_seq[3] = 8'h01;
    for (int i = 0; i < 4; i++) begin
      q_byte[i] = boot_seq[i]; q_rs[i] = 1'b0; q_boot[i] = 1'b1;
    end
    wr = 4;
    seed = $urandom(32'd1234);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!lcd_en && !lcd_rs && !lcd_rw && !req_ready, "R1", "outputs in reset",
        {lcd_en, lcd_rs, lcd_rw, req_ready}, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(!lcd_en && !lcd_rw && !req_ready, "R1", "first cycle after reset",
        {lcd_en, lcd_rw, req_ready}, 0);

    do @(negedge clk); while (!req_ready);
    chk(rd == 4, "R2", "boot writes before ready", rd, 4);

    // directed corners
    send(1'b0, 8'h01, 1'b0);  // clear: long wait
    send(1'b1, 8'h01, 1'b0);  // character 0x01: short wait
    send(1'b1, 8'h48, 1'b1);  // character with a busy-time poke
    send(1'b0, 8'h80, 1'b1);  // instruction with a busy-time poke
    send(1'b1, 8'h69, 1'b0);

    for (int n = 0; n < 40; n++) begin
      bit d;
      logic [7:0] b;
      int gap;
      d = $urandom_range(1, 0);
      b = 8'($urandom_range(255, 0));
      if ($urandom_range(5, 0) == 0) begin d = 1'b0; b = 8'h01; end
      send(d, b, $urandom_range(3, 0) == 0);
      gap = $urandom_range(3, 0);
      repeat (gap) @(posedge clk);
    end

    do @(negedge clk); while (!req_ready);
    repeat (5) @(negedge clk);
    chk(rd == wr, "R9", "strobes match accepted requests", rd, wr);
    chk(!lcd_en, "R9", "no strobe while idle", lcd_en, 0);
    finish_run();
  end

endmodule